// File: doc/BRIEF.md
# Platform Sleep State Transition Controller

This block holds the sleep state of one processor package and moves it only when a chipset sends a power-management request, or when reset is applied. It never starts a transition on its own. Each request carries a two-bit target code. The block checks that code against a fixed, asymmetric table of legal moves. Some states can be left by a request. Others can be left only by reset, which returns the block to the working state.

A legal request updates the state on the next clock edge. It also sets the level outputs that ask for core low power or memory self-refresh. When the new state is a sleep state, the block issues a completion message that names that state. The completion stays valid until the receiver takes it. While it is pending, no new request is accepted. An illegal request is never silently dropped: it produces a one-cycle machine-check pulse that carries the rejected code, and the state does not change.

Top module: `slp_state_ctrl`

## Requirements
- R1: While reset is active and after it ends, the state reads working (code 0), both low-power outputs are low, no completion is valid and no machine check is raised. The state codes are: 0 = working, 1 = light sleep, 2 = suspend to memory, 3 = deep sleep/off.
- R2: In the working state, a request with target 1 moves the block to light sleep and raises the core low-power output. It also presents a completion with code 1.
- R3: In the working state, a request with target 0, 2 or 3 is illegal. It raises machine check and leaves the state and outputs unchanged.
- R4: In light sleep, a request with target 0 returns the block to working, drops core low power and produces no completion.
- R5: In light sleep, a request with target 2 enters suspend to memory. The block raises the memory self-refresh output, drops core low power and presents a completion with code 2. Core low power and self-refresh are never high together.
- R6: In light sleep, a request with target 3 enters deep sleep/off with both low-power outputs low and presents a completion with code 3.
- R7: In suspend to memory and in deep sleep/off, every request (codes 0 to 3) raises machine check and the state holds. Only reset brings the block back to working.
- R8: A request whose target equals the current state is illegal and raises machine check.
- R9: The machine-check output is high for exactly the one cycle after an illegal request is accepted. Its code output equals the rejected target.
- R10: A completion stays valid with a stable code until it is taken with a ready/valid handshake. While it is pending, the request ready output is low and requests are neither accepted nor checked.
- R11: Reset returns the block to working from any state, drops both low-power outputs and clears a pending completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Power-management request present |
| req_ready | output | 1 | Block can accept a request (low while a completion is pending) |
| req_target | input | 2 | Requested target state code |
| cmp_valid | output | 1 | Completion message valid |
| cmp_ready | input | 1 | Receiver takes the completion |
| cmp_state | output | 2 | State code named by the completion |
| mce_pulse | output | 1 | One-cycle machine-check error |
| mce_code | output | 2 | Rejected target code, valid with mce_pulse |
| cur_state | output | 2 | Current sleep state code |
| core_lowpwr | output | 1 | Core low-power request level (light sleep) |
| mem_selfrefresh | output | 1 | Memory self-refresh request level (suspend to memory) |

## Verification
The bench drives every target code from every state. A design with a symmetric or incomplete table would either move the state out of suspend or deep sleep, or accept working-to-suspend directly. Both show up as a wrong state or a missing machine-check pulse. The bench also requests the current state itself, which catches a design that treats a same-state request as a no-op rather than an error. It holds a request while a completion is pending and checks that the state and the machine-check output stay quiet, so a design that ignores the stall is caught. It checks that leaving light sleep for working produces no completion, and that the machine-check pulse falls after one cycle. Finally, it applies reset with a completion still outstanding, which exposes a design that keeps a stale message.

// File: rtl/slp_pkg.sv
package slp_pkg;

  localparam int unsigned SLP_CODE_W = 2;

  typedef enum logic [SLP_CODE_W-1:0] {
    SLP_S0  = 2'd0,
    SLP_S1  = 2'd1,
    SLP_S3  = 2'd2,
    SLP_S45 = 2'd3
  } slp_state_e;

  // A completion is issued only when a sleep state is entered.
  function automatic logic slp_needs_cmp(input slp_state_e dst);
    return (dst != SLP_S0);
  endfunction

endpackage

// File: rtl/slp_rst_sync.sv
module slp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/slp_xition_table.sv
module slp_xition_table
  import slp_pkg::*;
(
  input  slp_state_e cur,
  input  slp_state_e dst,
  output logic       legal
);

  // Each row lists the targets that a request may reach from that state.
  // Reset-only exits have no entry here.
  always_comb begin
    legal = 1'b0;
    unique case (cur)
      SLP_S0:  legal = (dst == SLP_S1);
      SLP_S1:  legal = (dst == SLP_S0) || (dst == SLP_S3) || (dst == SLP_S45);
      SLP_S3:  legal = 1'b0;
      SLP_S45: legal = 1'b0;
      default: legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/slp_cmp_buf.sv
module slp_cmp_buf #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         vld_d;
  logic         data_en;

  always_comb begin
    vld_d   = out_valid;
    data_en = 1'b0;
    if (out_valid && out_ready) begin
      vld_d = 1'b0;
    end
    if (load) begin
      vld_d   = 1'b1;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (data_en) begin
      out_data <= load_data;
    end
  end

endmodule

// File: rtl/slp_state_ctrl.sv
module slp_state_ctrl
  import slp_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_target,
  output logic       cmp_valid,
  input  logic       cmp_ready,
  output logic [1:0] cmp_state,
  output logic       mce_pulse,
  output logic [1:0] mce_code,
  output logic [1:0] cur_state,
  output logic       core_lowpwr,
  output logic       mem_selfrefresh
);

  logic       rst_n_i;
  slp_state_e state_q, state_d, dst;
  logic       legal, accept, take;
  logic       core_d, mem_d, mce_d;
  logic       mce_code_en;

  slp_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign dst = slp_state_e'(req_target);

  slp_xition_table u_table (
    .cur   (state_q),
    .dst   (dst),
    .legal (legal)
  );

  assign req_ready = !cmp_valid;
  assign accept    = req_valid && req_ready;
  assign take      = accept && legal;

  // Next-state logic
  always_comb begin
    state_d     = state_q;
    mce_d       = 1'b0;
    mce_code_en = 1'b0;
    if (accept) begin
      if (legal) begin
        state_d = dst;
      end else begin
        mce_d       = 1'b1;
        mce_code_en = 1'b1;
      end
    end
    core_d = (state_d == SLP_S1);
    mem_d  = (state_d == SLP_S3);
  end

  // State and control registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q         <= SLP_S0;
      core_lowpwr     <= 1'b0;
      mem_selfrefresh <= 1'b0;
      mce_pulse       <= 1'b0;
    end else begin
      state_q         <= state_d;
      core_lowpwr     <= core_d;
      mem_selfrefresh <= mem_d;
      mce_pulse       <= mce_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      mce_code <= '0;
    end else if (mce_code_en) begin
      mce_code <= req_target;
    end
  end

  slp_cmp_buf #(.W(SLP_CODE_W)) u_cmp (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .load      (take && slp_needs_cmp(dst)),
    .load_data (req_target),
    .out_valid (cmp_valid),
    .out_ready (cmp_ready),
    .out_data  (cmp_state)
  );

  assign cur_state = state_q;

endmodule

// File: rtl/slp_state_ctrl_chk.sv
module slp_state_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [1:0] req_target,
  input logic       cmp_valid,
  input logic       cmp_ready,
  input logic [1:0] cmp_state,
  input logic       mce_pulse,
  input logic [1:0] mce_code,
  input logic [1:0] cur_state,
  input logic       core_lowpwr,
  input logic       mem_selfrefresh
);

  assert_mce_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mce_pulse |-> ($past(req_valid && req_ready) && mce_code == $past(req_target)));

  assert_mce_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mce_pulse |-> (cur_state == $past(cur_state)));

  assert_cmp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !cmp_ready) |=> (cmp_valid && $stable(cmp_state)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> !req_ready);

  assert_s3_stuck_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 2'd2) |=> (cur_state == 2'd2));

  assert_s45_stuck_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 2'd3) |=> (cur_state == 2'd3));

  assert_s0_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_state == 2'd0) |=> (cur_state == 2'd0 || cur_state == 2'd1));

  assert_lowpwr_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(core_lowpwr && mem_selfrefresh));

endmodule

bind slp_state_ctrl slp_state_ctrl_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .req_valid       (req_valid),
  .req_ready       (req_ready),
  .req_target      (req_target),
  .cmp_valid       (cmp_valid),
  .cmp_ready       (cmp_ready),
  .cmp_state       (cmp_state),
  .mce_pulse       (mce_pulse),
  .mce_code        (mce_code),
  .cur_state       (cur_state),
  .core_lowpwr     (core_lowpwr),
  .mem_selfrefresh (mem_selfrefresh)
);

// File: tb/slp_state_ctrl_tb.sv
`timescale 1ns/1ps
module slp_state_ctrl_tb;

  logic       clk;
  logic       rst_n;
  logic       req_valid;
  logic       req_ready;
  logic [1:0] req_target;
  logic       cmp_valid;
  logic       cmp_ready;
  logic [1:0] cmp_state;
  logic       mce_pulse;
  logic [1:0] mce_code;
  logic [1:0] cur_state;
  logic       core_lowpwr;
  logic       mem_selfrefresh;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  slp_state_ctrl u_dut (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_ready       (req_ready),
    .req_target      (req_target),
    .cmp_valid       (cmp_valid),
    .cmp_ready       (cmp_ready),
    .cmp_state       (cmp_state),
    .mce_pulse       (mce_pulse),
    .mce_code        (mce_code),
    .cur_state       (cur_state),
    .core_lowpwr     (core_lowpwr),
    .mem_selfrefresh (mem_selfrefresh)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Drive one request for one accepted cycle; returns 2 ns after the edge.
  task automatic send(input logic [1:0] tgt);
    @(negedge clk);
    req_valid  = 1'b1;
    req_target = tgt;
    @(posedge clk);
    #2;
    req_valid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk);
    cmp_ready = 1'b1;
    @(posedge clk);
    #2;
    cmp_ready = 1'b0;
  endtask

  task automatic expect_mce(input string req, input logic [1:0] tgt, input logic [1:0] st);
    send(tgt);
    chk({req, " mce raised"}, mce_pulse, 1);
    chk({req, " mce code"}, mce_code, tgt);
    chk({req, " state held"}, cur_state, st);
    chk({req, " no completion"}, cmp_valid, 0);
    @(posedge clk);
    #2;
    chk("R9 mce one cycle", mce_pulse, 0);
  endtask

  task automatic t_reset();
    chk("R1 state", cur_state, 0);
    chk("R1 core", core_lowpwr, 0);
    chk("R1 mem", mem_selfrefresh, 0);
    chk("R1 cmp", cmp_valid, 0);
    chk("R1 mce", mce_pulse, 0);
    chk("R1 ready", req_ready, 1);
  endtask

  task automatic t_s0_illegal();
    expect_mce("R3 S0->S3", 2'd2, 2'd0);
    expect_mce("R3 S0->S45", 2'd3, 2'd0);
    expect_mce("R8 S0->S0", 2'd0, 2'd0);
    chk("R3 core stays low", core_lowpwr, 0);
  endtask

  task automatic t_s0_to_s1();
    send(2'd1);
    chk("R2 state", cur_state, 1);
    chk("R2 core", core_lowpwr, 1);
    chk("R2 cmp valid", cmp_valid, 1);
    chk("R2 cmp code", cmp_state, 1);
    chk("R2 mce", mce_pulse, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    req_valid  = 1'b1;
    req_target = 2'd0;
    repeat (3) begin
      @(posedge clk);
      #2;
      chk("R10 ready low", req_ready, 0);
      chk("R10 state held", cur_state, 1);
      chk("R10 no mce", mce_pulse, 0);
      chk("R10 cmp stable", cmp_state, 1);
    end
    req_valid = 1'b0;
    ack();
    chk("R10 cmp taken", cmp_valid, 0);
    chk("R10 ready back", req_ready, 1);
  endtask

  task automatic t_s1_self();
    expect_mce("R8 S1->S1", 2'd1, 2'd1);
    chk("R8 core kept", core_lowpwr, 1);
  endtask

  task automatic t_s1_to_s0();
    send(2'd0);
    chk("R4 state", cur_state, 0);
    chk("R4 core", core_lowpwr, 0);
    chk("R4 no cmp", cmp_valid, 0);
    @(posedge clk);
    #2;
    chk("R4 still no cmp", cmp_valid, 0);
  endtask

  task automatic t_s3();
    send(2'd1);
    ack();
    send(2'd2);
    chk("R5 state", cur_state, 2);
    chk("R5 mem", mem_selfrefresh, 1);
    chk("R5 core", core_lowpwr, 0);
    chk("R5 cmp code", cmp_state, 2);
    chk("R5 cmp valid", cmp_valid, 1);
    ack();
    for (int t = 0; t < 4; t++) expect_mce("R7 from S3", 2'(t), 2'd2);
    chk("R7 mem kept", mem_selfrefresh, 1);
    do_reset();
    chk("R11 S3 reset state", cur_state, 0);
    chk("R11 S3 reset mem", mem_selfrefresh, 0);
  endtask

  task automatic t_s45();
    send(2'd1);
    ack();
    send(2'd3);
    chk("R6 state", cur_state, 3);
    chk("R6 core", core_lowpwr, 0);
    chk("R6 mem", mem_selfrefresh, 0);
    chk("R6 cmp code", cmp_state, 3);
    ack();
    for (int t = 0; t < 4; t++) expect_mce("R7 from S45", 2'(t), 2'd3);
    do_reset();
    chk("R11 S45 reset state", cur_state, 0);
  endtask

  task automatic t_reset_pending();
    send(2'd1);
    chk("R11 pre cmp", cmp_valid, 1);
    do_reset();
    chk("R11 cmp cleared", cmp_valid, 0);
    chk("R11 state", cur_state, 0);
    chk("R11 core", core_lowpwr, 0);
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_target = 2'd0;
    cmp_ready  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_s0_illegal();
    t_s0_to_s1();
    t_stall();
    t_s1_self();
    t_s1_to_s0();
    t_s3();
    t_s45();
    t_reset_pending();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule